// File: doc/BRIEF.md
# Transmit/Receive Byte FIFO Pair with Threshold Interrupts

This block holds two byte queues that sit between a serial shift engine and a host bus. The host fills the transmit queue and the engine drains it; the engine fills the receive queue and the host drains it. Each queue has its own programmable threshold. The receive side raises a "data ready" event when enough bytes are waiting. The transmit side raises a "running low" event when few enough bytes remain. Either event can feed a DMA request line instead of, or as well as, the interrupt.

Events are latched into sticky status bits. Software clears them by writing ones. A per-bit enable mask gates them onto a single interrupt line. A receive push that finds the queue full is dropped and latched as an overflow event. A transfer-done pulse from the engine is latched as a fourth event. A control write can flush either queue. The flush bit reads back set for one cycle, then clears itself.

Top module: `dual_fifo_trig`

## Requirements
- R1: Each queue returns bytes in the order they were pushed. Its occupancy appears on its count port. Register address 1 reads the receive count in bits [7:0] and the transmit count in bits [23:16].
- R2: A receive push while the receive queue holds DEPTH bytes is dropped, and status bit 8 (overflow) is set. A transmit push into a full transmit queue is dropped. A pop from an empty queue leaves its count at 0.
- R3: Status bit 0 (receive ready) is set on the clock edge after a cycle in which the receive count is at or above the receive threshold, control bits [7:0].
- R4: Status bit 4 (transmit low) is set on the clock edge after a cycle in which the transmit count is at or below the transmit threshold, control bits [23:16].
- R5: Status bits at address 3 are sticky. Writing 1 to a bit clears it, unless its set condition holds in that same cycle, in which case it stays set. Writing 0 has no effect. Writing all ones clears every bit whose condition is absent.
- R6: The irq output is high exactly when some status bit is set and its enable bit is set. The enable register sits at address 2 and keeps only bits 0, 4, 8 and 12; all other bits read 0.
- R7: rx_dma_req is high when control bit 8 is set, the receive count is at or above the receive threshold, and the count is nonzero. tx_dma_req is high when control bit 24 is set, the transmit count is at or below the transmit threshold, and the queue is not full.
- R8: A control write (address 0) with bit 15 set empties the receive queue at that edge. A write with bit 31 set empties the transmit queue. The other queue is untouched. The written flush bit reads back 1 for one cycle and then 0.
- R9: A pulse on xfer_done sets status bit 12.
- R10: After reset both counts are 0. Control reads 3/4·DEPTH in bits [7:0] and DEPTH/4 in bits [23:16]. The enables are 0, so irq and both DMA requests are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 levels, 2 enable, 3 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| tx_push | input | 1 | Host writes a transmit byte |
| tx_wdata | input | 8 | Transmit byte |
| tx_pop | input | 1 | Engine takes the transmit head |
| tx_rdata | output | 8 | Transmit head byte |
| rx_push | input | 1 | Engine delivers a received byte |
| rx_wdata | input | 8 | Received byte |
| rx_pop | input | 1 | Host takes the receive head |
| rx_rdata | output | 8 | Receive head byte |
| xfer_done | input | 1 | Transfer-complete pulse from the engine |
| tx_count | output | $clog2(DEPTH+1) | Transmit occupancy |
| rx_count | output | $clog2(DEPTH+1) | Receive occupancy |
| irq | output | 1 | Combined interrupt |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |

## Verification
Short bursts of distinct bytes pass through each queue. This separates ordering faults from count faults. A full fill plus one extra push, with a marker value that must never reappear, separates drop-on-full from overwrite. Thresholds are probed one byte below, at, and one above the level. Each clear is issued both while the condition persists and after it has gone. This tells an inclusive comparison from an exclusive one, and set-wins from clear-wins. Flush and DMA patterns toggle one queue while the other holds data, which exposes any cross-coupling between the two sides.

// File: rtl/dft_pkg.sv
package dft_pkg;

    localparam int unsigned REG_W  = 32;
    localparam int unsigned TRIG_W = 8;
    localparam int unsigned EV_N   = 4;

    // event index order: 0 receive ready, 1 transmit low, 2 overflow, 3 done
    typedef enum logic [1:0] {
        ADDR_CTRL  = 2'd0,
        ADDR_LEVEL = 2'd1,
        ADDR_IEN   = 2'd2,
        ADDR_ISTA  = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic [TRIG_W-1:0] tx_trig;
        logic              tx_dma_en;
        logic              tx_flush;
        logic [TRIG_W-1:0] rx_trig;
        logic              rx_dma_en;
        logic              rx_flush;
    } fifo_ctrl_t;

    function automatic fifo_ctrl_t ctrl_from_word(input logic [REG_W-1:0] w);
        fifo_ctrl_t c;
        c.rx_trig   = w[7:0];
        c.rx_dma_en = w[8];
        c.rx_flush  = w[15];
        c.tx_trig   = w[23:16];
        c.tx_dma_en = w[24];
        c.tx_flush  = w[31];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] ctrl_to_word(input fifo_ctrl_t c);
        logic [REG_W-1:0] w;
        w        = '0;
        w[7:0]   = c.rx_trig;
        w[8]     = c.rx_dma_en;
        w[15]    = c.rx_flush;
        w[23:16] = c.tx_trig;
        w[24]    = c.tx_dma_en;
        w[31]    = c.tx_flush;
        return w;
    endfunction

    // event i lives at register bit 4*i
    function automatic logic [REG_W-1:0] ev_spread(input logic [EV_N-1:0] v);
        logic [REG_W-1:0] w;
        w = '0;
        for (int i = 0; i < EV_N; i++) w[4*i] = v[i];
        return w;
    endfunction

    function automatic logic [EV_N-1:0] ev_gather(input logic [REG_W-1:0] w);
        logic [EV_N-1:0] v;
        for (int i = 0; i < EV_N; i++) v[i] = w[4*i];
        return v;
    endfunction

endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
    parameter  int unsigned DEPTH = 64,
    parameter  int unsigned DW    = 8,
    localparam int unsigned AW    = $clog2(DEPTH),
    localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] rdata,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          drop
);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && (count != '0) && !flush;
    assign drop    = push && full && !flush;
    assign rdata   = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= ptr_next(wr_ptr);
            if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/sticky_events.sv
module sticky_events #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    input  logic         ien_we,
    input  logic [N-1:0] ien_wdata,
    output logic [N-1:0] ista,
    output logic [N-1:0] ien,
    output logic         irq
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)         ista[i] <= 1'b0;
            else if (set[i]) ista[i] <= 1'b1;
            else if (clr[i]) ista[i] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         ien <= '0;
        else if (ien_we) ien <= ien_wdata;
    end

    assign irq = |(ista & ien);

endmodule

// File: rtl/dual_fifo_trig.sv
module dual_fifo_trig
    import dft_pkg::*;
#(
    parameter  int unsigned DEPTH = 64,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wen,
    input  logic [1:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic             tx_push,
    input  logic [7:0]       tx_wdata,
    input  logic             tx_pop,
    output logic [7:0]       tx_rdata,
    input  logic             rx_push,
    input  logic [7:0]       rx_wdata,
    input  logic             rx_pop,
    output logic [7:0]       rx_rdata,
    input  logic             xfer_done,
    output logic [CNT_W-1:0] tx_count,
    output logic [CNT_W-1:0] rx_count,
    output logic             irq,
    output logic             tx_dma_req,
    output logic             rx_dma_req
);

    localparam logic [TRIG_W-1:0] RX_TRIG_RST = TRIG_W'(DEPTH / 4 * 3);
    localparam logic [TRIG_W-1:0] TX_TRIG_RST = TRIG_W'(DEPTH / 4);

    fifo_ctrl_t      ctrl_q, ctrl_wr;
    logic            ctrl_we, ien_we, ista_we;
    logic            rx_flush_now, tx_flush_now;
    logic            rx_full, tx_full, rx_drop, tx_drop;
    logic            rx_at_trig, tx_at_trig;
    logic [EV_N-1:0] ev_set, ev_clr, ista, ien;
    logic            unused_bits;

    assign ctrl_we  = reg_wen && (reg_addr == ADDR_CTRL);
    assign ien_we   = reg_wen && (reg_addr == ADDR_IEN);
    assign ista_we  = reg_wen && (reg_addr == ADDR_ISTA);
    assign ctrl_wr  = ctrl_from_word(reg_wdata);

    assign rx_flush_now = ctrl_we && ctrl_wr.rx_flush;
    assign tx_flush_now = ctrl_we && ctrl_wr.tx_flush;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q           <= '0;
            ctrl_q.rx_trig   <= RX_TRIG_RST;
            ctrl_q.tx_trig   <= TX_TRIG_RST;
        end else if (ctrl_we) begin
            ctrl_q <= ctrl_wr;
        end else begin
            ctrl_q.rx_flush <= 1'b0;
            ctrl_q.tx_flush <= 1'b0;
        end
    end

    byte_fifo #(.DEPTH(DEPTH), .DW(8)) u_tx_fifo (
        .clk   (clk),
        .rst   (rst),
        .flush (tx_flush_now),
        .push  (tx_push),
        .wdata (tx_wdata),
        .pop   (tx_pop),
        .rdata (tx_rdata),
        .count (tx_count),
        .full  (tx_full),
        .drop  (tx_drop)
    );

    byte_fifo #(.DEPTH(DEPTH), .DW(8)) u_rx_fifo (
        .clk   (clk),
        .rst   (rst),
        .flush (rx_flush_now),
        .push  (rx_push),
        .wdata (rx_wdata),
        .pop   (rx_pop),
        .rdata (rx_rdata),
        .count (rx_count),
        .full  (rx_full),
        .drop  (rx_drop)
    );

    assign rx_at_trig = (32'(rx_count) >= 32'(ctrl_q.rx_trig));
    assign tx_at_trig = (32'(tx_count) <= 32'(ctrl_q.tx_trig));

    assign ev_set = {xfer_done, rx_drop, tx_at_trig, rx_at_trig};
    assign ev_clr = ista_we ? ev_gather(reg_wdata) : '0;

    sticky_events #(.N(EV_N)) u_events (
        .clk       (clk),
        .rst       (rst),
        .set       (ev_set),
        .clr       (ev_clr),
        .ien_we    (ien_we),
        .ien_wdata (ev_gather(reg_wdata)),
        .ista      (ista),
        .ien       (ien),
        .irq       (irq)
    );

    assign rx_dma_req = ctrl_q.rx_dma_en && rx_at_trig && (rx_count != '0);
    assign tx_dma_req = ctrl_q.tx_dma_en && tx_at_trig && !tx_full;

    always_comb begin
        unique case (reg_addr)
            ADDR_CTRL:  reg_rdata = ctrl_to_word(ctrl_q);
            ADDR_LEVEL: reg_rdata = {8'h00, 8'(tx_count), 8'h00, 8'(rx_count)};
            ADDR_IEN:   reg_rdata = ev_spread(ien);
            default:    reg_rdata = ev_spread(ista);
        endcase
    end

    assign unused_bits = ^{reg_wdata[14:13], reg_wdata[11:9], reg_wdata[30:25], tx_drop, rx_full};

endmodule

// File: rtl/dft_checker.sv
module dft_checker #(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned CW    = 7
) (
    input logic          clk,
    input logic          rst,
    input logic          reg_wen,
    input logic [1:0]    reg_addr,
    input logic [31:0]   reg_wdata,
    input logic          rx_push,
    input logic          xfer_done,
    input logic [CW-1:0] rx_count,
    input logic [CW-1:0] tx_count,
    input logic [7:0]    rx_trig,
    input logic [7:0]    tx_trig,
    input logic          rx_flush_q,
    input logic [3:0]    ista,
    input logic          rx_dma_req,
    input logic          tx_dma_req
);

    // R1: occupancy never exceeds depth
    a_r1_count_bound: assert property (@(posedge clk) disable iff (rst)
        (32'(rx_count) <= DEPTH) && (32'(tx_count) <= DEPTH));

    // R2: push into a full receive queue latches overflow
    a_r2_overflow: assert property (@(posedge clk) disable iff (rst)
        (rx_push && 32'(rx_count) == DEPTH && !(reg_wen && reg_addr == 2'd0 && reg_wdata[15]))
        |=> ista[2]);

    // R3: receive count at threshold latches receive ready
    a_r3_rx_ready: assert property (@(posedge clk) disable iff (rst)
        (32'(rx_count) >= 32'(rx_trig)) |=> ista[0]);

    // R4: transmit count at threshold latches transmit low
    a_r4_tx_low: assert property (@(posedge clk) disable iff (rst)
        (32'(tx_count) <= 32'(tx_trig)) |=> ista[1]);

    // R5: a set bit holds without a status write
    a_r5_sticky: assert property (@(posedge clk) disable iff (rst)
        (ista[2] && !(reg_wen && reg_addr == 2'd3)) |=> ista[2]);

    // R7: requests never point at an empty or full queue
    a_r7_dma_safe: assert property (@(posedge clk) disable iff (rst)
        (rx_dma_req |-> rx_count != '0) and (tx_dma_req |-> 32'(tx_count) != DEPTH));

    // R8: flush bit clears itself unless rewritten
    a_r8_flush_pulse: assert property (@(posedge clk) disable iff (rst)
        (rx_flush_q && !(reg_wen && reg_addr == 2'd0 && reg_wdata[15])) |=> !rx_flush_q);

    // R9: done pulse latches
    a_r9_done: assert property (@(posedge clk) disable iff (rst)
        xfer_done |=> ista[3]);

endmodule

bind dual_fifo_trig dft_checker #(.DEPTH(DEPTH), .CW(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_wen    (reg_wen),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .rx_push    (rx_push),
    .xfer_done  (xfer_done),
    .rx_count   (rx_count),
    .tx_count   (tx_count),
    .rx_trig    (ctrl_q.rx_trig),
    .tx_trig    (ctrl_q.tx_trig),
    .rx_flush_q (ctrl_q.rx_flush),
    .ista       (ista),
    .rx_dma_req (rx_dma_req),
    .tx_dma_req (tx_dma_req)
);

// File: tb/test_dual_fifo_trig.sv
module test_dual_fifo_trig;

    localparam int DEPTH = 64;
    localparam int CW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_wen = 1'b0;
    logic [1:0]    reg_addr = 2'd0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
    logic [7:0]    tx_wdata = '0, rx_wdata = '0, tx_rdata, rx_rdata;
    logic          xfer_done = 1'b0;
    logic [CW-1:0] tx_count, rx_count;
    logic          irq, tx_dma_req, rx_dma_req;

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] txq[$];
    logic [7:0] rxq[$];
    logic [31:0] rv;

    always #5 clk = ~clk;

    dual_fifo_trig #(.DEPTH(DEPTH)) i_dual_fifo_trig (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
        step(1);
        reg_wen = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic drive_tx(input logic [7:0] b, input bit expect_keep);
        if (expect_keep) txq.push_back(b);
        tx_push = 1'b1; tx_wdata = b; step(1); tx_push = 1'b0;
    endtask

    task automatic drive_rx(input logic [7:0] b, input bit expect_keep);
        if (expect_keep) rxq.push_back(b);
        rx_push = 1'b1; rx_wdata = b; step(1); rx_push = 1'b0;
    endtask

    task automatic take_tx(); tx_pop = 1'b1; step(1); tx_pop = 1'b0; endtask
    task automatic take_rx(); rx_pop = 1'b1; step(1); rx_pop = 1'b0; endtask

    // scoreboard monitor: compare the head against the expected queue on each pop
    always @(negedge clk) begin
        if (tx_pop && txq.size() > 0) chk("R1 tx order", 32'(tx_rdata), 32'(txq.pop_front()));
        if (rx_pop && rxq.size() > 0) chk("R1/R2 rx order", 32'(rx_rdata), 32'(rxq.pop_front()));
    end

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        step(3); rst = 1'b0; step(2);
        // R10 reset state
        chk("R10 rx_count", 32'(rx_count), 0);
        chk("R10 tx_count", 32'(tx_count), 0);
        chk("R10 irq/dma", {29'd0, irq, tx_dma_req, rx_dma_req}, 0);
        rd(2'd0, rv); chk("R10 ctrl", rv, 32'h0010_0030);
        rd(2'd3, rv); chk("R4 low after reset", rv, 32'h0000_0010);

        // R5 clear all while transmit-low condition persists
        wr(2'd3, 32'hFFFF_FFFF); step(1);
        rd(2'd3, rv); chk("R5 set wins over clear", rv, 32'h0000_0010);

        // R1 transmit ordering and counts
        for (int i = 0; i < 5; i++) drive_tx(8'hA0 + 8'(i), 1'b1);
        chk("R1 tx_count", 32'(tx_count), 5);
        rd(2'd1, rv); chk("R1 level word", rv, 32'h0005_0000);
        for (int i = 0; i < 5; i++) take_tx();
        chk("R1 tx empty", 32'(tx_count), 0);

        // R3 receive threshold 4, transmit threshold 2
        wr(2'd0, 32'h0002_0004);
        for (int i = 0; i < 3; i++) drive_rx(8'h30 + 8'(i), 1'b1);
        step(1); rd(2'd3, rv); chk("R3 below level", {31'd0, rv[0]}, 0);
        drive_rx(8'h33, 1'b1);
        step(1); rd(2'd3, rv); chk("R3 at level", {31'd0, rv[0]}, 1);
        take_rx(); step(1);
        wr(2'd3, 32'h0); step(1);
        rd(2'd3, rv); chk("R5 zero write no effect", {31'd0, rv[0]}, 1);
        wr(2'd3, 32'h1); step(1);
        rd(2'd3, rv); chk("R5 clear after condition gone", {31'd0, rv[0]}, 0);

        // R4 transmit low
        for (int i = 0; i < 3; i++) drive_tx(8'h50 + 8'(i), 1'b1);
        wr(2'd3, 32'h10); step(1);
        rd(2'd3, rv); chk("R4 above level clears", {31'd0, rv[4]}, 0);
        take_tx(); step(1);
        rd(2'd3, rv); chk("R4 at level sets", {31'd0, rv[4]}, 1);

        // R6 enable mask
        wr(2'd2, 32'h10); chk("R6 irq on", 32'(irq), 1);
        wr(2'd2, 32'hFFFF_FFFF);
        rd(2'd2, rv); chk("R6 enable readback", rv, 32'h0000_1111);
        wr(2'd2, 32'h1); chk("R6 irq masked", 32'(irq), 0);
        wr(2'd2, 32'h0);

        // R8 receive flush, transmit untouched
        wr(2'd0, 32'h0002_8004); rxq.delete();
        chk("R8 rx flushed", 32'(rx_count), 0);
        chk("R8 tx kept", 32'(tx_count), 2);
        rd(2'd0, rv); chk("R8 flush bit one cycle", {31'd0, rv[15]}, 1);
        step(1); rd(2'd0, rv); chk("R8 flush bit cleared", {31'd0, rv[15]}, 0);

        // R2 overflow on full receive queue
        for (int i = 0; i < DEPTH; i++) drive_rx(8'(i * 3 + 1), 1'b1);
        drive_rx(8'hEE, 1'b0); step(1);
        chk("R2 rx full count", 32'(rx_count), DEPTH);
        rd(2'd3, rv); chk("R2 overflow bit", {31'd0, rv[8]}, 1);
        for (int i = 0; i < DEPTH; i++) take_rx();
        take_rx();
        chk("R2 pop empty", 32'(rx_count), 0);

        // R7 DMA requests
        wr(2'd0, 32'h0102_0104);
        chk("R7 rx req empty", 32'(rx_dma_req), 0);
        chk("R7 tx req at level", 32'(tx_dma_req), 1);
        for (int i = 0; i < 4; i++) drive_rx(8'hC0 + 8'(i), 1'b1);
        chk("R7 rx req at level", 32'(rx_dma_req), 1);
        wr(2'd0, 32'h0002_0004);
        chk("R7 reqs disabled", {30'd0, tx_dma_req, rx_dma_req}, 0);

        // R9 transfer done
        xfer_done = 1'b1; step(1); xfer_done = 1'b0;
        rd(2'd3, rv); chk("R9 done bit", {31'd0, rv[12]}, 1);
        wr(2'd3, 32'h1000); step(1);
        rd(2'd3, rv); chk("R9 done cleared", {31'd0, rv[12]}, 0);

        // R8 transmit flush, receive untouched
        wr(2'd0, 32'h8000_0000); txq.delete();
        chk("R8 tx flushed", 32'(tx_count), 0);
        chk("R8 rx kept", 32'(rx_count), 4);
        for (int i = 0; i < 4; i++) take_rx();

        // R2 transmit push into full queue dropped
        for (int i = 0; i < DEPTH; i++) drive_tx(8'(i ^ 8'h5A), 1'b1);
        drive_tx(8'hEE, 1'b0);
        chk("R2 tx full count", 32'(tx_count), DEPTH);
        for (int i = 0; i < DEPTH; i++) take_tx();
        chk("R2 tx drained", 32'(tx_count), 0);

        step(2);
        finish_run();
    end

endmodule